// File: doc/BRIEF.md
# I/O Configuration Unlock and Window Decoder

This block is a configuration engine and address decoder on a byte-wide host I/O bus with a 16-bit address, a write data byte, a read data byte and separate read and write strobes. Configuration space is locked after reset. Software opens it by writing a magic byte to a fixed configuration port. It then uses an index/data register pair to pick a logical device, turn on that device's activate bit, and fill a table of I/O window entries. Another magic byte to the same port locks it again.

Each window entry is four configuration registers: a size mask, a valid flag with a target device number, and a 16-bit base address stored low byte first. While configuration is locked, the block compares every host read or write cycle with the valid windows whose target device is active. On a hit it drives a one-hot device select and the byte offset within the window. The device functions behind the decode are outside this block.

Top module: `pnp_cfg_decoder`

## Requirements
- R1: Configuration opens when 0x55 is written to the index port (address CFG_BASE, default 0x002E) while locked. It closes when 0xAA is written there while open. Any other value written to the index port while locked leaves it locked.
- R2: While locked, writes to the data port (CFG_BASE+1) change nothing, and reads of the index port or the data port return 0xFF.
- R3: While open, a write to the index port with any value other than 0xAA loads the index register, and a read of the index port returns it. Register 0x07 holds the selected device number in bits 3:0 and is read back at the data port.
- R4: Register 0x30 bit 0 is the activate bit of the selected device. It reads back in bit 0, with bits 7:1 zero.
- R5: Window entry i sits at registers 0x60+4i to 0x63+4i of device 0x0C. Byte 0 is the mask. Byte 1 holds the valid flag in bit 7 and the target device in bits 3:0, and its bits 6:4 read as zero. Byte 2 is the low base byte and byte 3 the high base byte. All of them read back at the data port while device 0x0C is selected.
- R6: A write to an entry register is ignored unless the selected device is 0x0C and device 0x0C is active.
- R7: While locked and while a read or write strobe is high, an entry hits when it is valid, its target device is active, and (addr & ~mask) equals (base & ~mask). On a hit, sel_hit is 1, sel_onehot has only the bit of the target device set, and sel_offset equals addr[7:0] & mask.
- R8: When more than one entry hits, the entry with the lowest number decides the select and the offset.
- R9: While configuration is open, or while neither strobe is high, sel_hit, sel_onehot and sel_offset are all zero.
- R10: Reset leaves the block locked. It clears the index, the device select, every activate bit and every entry field.
- R11: An entry whose base is 0x0000 never hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 16 | Host I/O address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the configuration ports |
| sel_hit | output | 1 | A window matched the current cycle |
| sel_onehot | output | 16 | One-hot select of the target logical device |
| sel_offset | output | 8 | Offset of the address within the window |

## Verification
Seven entries are set up. Together they cover 64-, 16-, 8- and 2-byte windows, a window nested inside another, a zero base, an inactive target device and an invalid entry. A vector table of addresses is then run against them. Each vector tells apart one case: an address on a window's first byte, last byte or first byte past the end; an address that hits two windows; an address that differs from a base only in its high bits. Directed sequences cover the rest. They check magic and non-magic writes to the index port, data-port writes made while locked, entry writes with the wrong device selected or the table device inactive, and the readback of the unused bits of byte 1. They also re-check priority after the winning entry is made invalid, and check decode suppression while configuration is open or no strobe is high.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;
  localparam int ADDR_W = 16;
  localparam int LDN_W  = 4;
  localparam int NDEV   = 1 << LDN_W;

  localparam logic [7:0] MAGIC_OPEN  = 8'h55;
  localparam logic [7:0] MAGIC_CLOSE = 8'hAA;
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_ACT     = 8'h30;

  typedef struct packed {
    logic [7:0]        mask;
    logic              vld;
    logic [LDN_W-1:0]  ldn;
    logic [ADDR_W-1:0] base;
  } bar_ent_t;

  typedef enum logic {
    CFG_LOCKED = 1'b0,
    CFG_OPEN   = 1'b1
  } cfg_state_e;

  // byte view of an entry as software sees it
  function automatic logic [7:0] ent_byte(bar_ent_t e, logic [1:0] sel);
    logic [7:0] b;
    case (sel)
      2'd0:    b = e.mask;
      2'd1:    b = {e.vld, {(7-LDN_W){1'b0}}, e.ldn};
      2'd2:    b = e.base[7:0];
      default: b = e.base[15:8];
    endcase
    return b;
  endfunction
endpackage

// File: rtl/pnp_unlock_fsm.sv
module pnp_unlock_fsm
  import pnp_cfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CFG_BASE = 16'h002E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  output logic              cfg_open
);
  cfg_state_e state_q, state_d;
  logic       idx_wr;

  assign idx_wr = host_wr && (host_addr == CFG_BASE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      CFG_LOCKED: if (idx_wr && host_wdata == MAGIC_OPEN)  state_d = CFG_OPEN;
      default:    if (idx_wr && host_wdata == MAGIC_CLOSE) state_d = CFG_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= CFG_LOCKED;
    else if (idx_wr) state_q <= state_d;
  end

  assign cfg_open = (state_q == CFG_OPEN);
endmodule

// File: rtl/pnp_cfg_regs.sv
module pnp_cfg_regs
  import pnp_cfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CFG_BASE = 16'h002E,
  parameter int                NENT     = 8,
  parameter logic [LDN_W-1:0]  TBL_LDN  = 4'hC,
  parameter logic [7:0]        TBL_BASE = 8'h60
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_open,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic                 host_wr,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           idx_q,
  output logic [7:0]           cfg_rdata,
  output logic [NDEV-1:0]      act_q,
  output bar_ent_t [NENT-1:0]  ent_q
);
  localparam int         ENT_W    = (NENT > 1) ? $clog2(NENT) : 1;
  localparam logic [8:0] TBL_SPAN = 9'(4 * NENT);

  logic [7:0]          idx_d;
  logic [LDN_W-1:0]    ldn_q, ldn_d;
  logic [NDEV-1:0]     act_d;
  bar_ent_t [NENT-1:0] ent_d;

  logic             idx_we, dat_we, reg_en;
  logic [7:0]       ofs;
  logic             in_tbl, tbl_ok;
  logic [ENT_W-1:0] ent_no;

  assign idx_we = cfg_open && host_wr && (host_addr == CFG_BASE) && (host_wdata != MAGIC_CLOSE);
  assign dat_we = cfg_open && host_wr && (host_addr == CFG_BASE + 1'b1);
  assign reg_en = idx_we || dat_we;

  assign ofs    = idx_q - TBL_BASE;
  assign in_tbl = (idx_q >= TBL_BASE) && ({1'b0, ofs} < TBL_SPAN);
  assign ent_no = ofs[ENT_W+1:2];
  assign tbl_ok = (ldn_q == TBL_LDN) && act_q[TBL_LDN];

  // next state
  always_comb begin
    idx_d = idx_q;
    ldn_d = ldn_q;
    act_d = act_q;
    ent_d = ent_q;
    if (idx_we) idx_d = host_wdata;
    if (dat_we) begin
      if (idx_q == REG_LDN) ldn_d = host_wdata[LDN_W-1:0];
      if (idx_q == REG_ACT) act_d[ldn_q] = host_wdata[0];
      if (in_tbl && tbl_ok) begin
        case (ofs[1:0])
          2'd0: ent_d[ent_no].mask = host_wdata;
          2'd1: begin
            ent_d[ent_no].vld = host_wdata[7];
            ent_d[ent_no].ldn = host_wdata[LDN_W-1:0];
          end
          2'd2:    ent_d[ent_no].base[7:0]  = host_wdata;
          default: ent_d[ent_no].base[15:8] = host_wdata;
        endcase
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      ldn_q <= '0;
      act_q <= '0;
      ent_q <= '0;
    end else if (reg_en) begin
      idx_q <= idx_d;
      ldn_q <= ldn_d;
      act_q <= act_d;
      ent_q <= ent_d;
    end
  end

  // data port read view
  always_comb begin
    cfg_rdata = 8'h00;
    if (idx_q == REG_LDN)                       cfg_rdata = {{(8-LDN_W){1'b0}}, ldn_q};
    else if (idx_q == REG_ACT)                  cfg_rdata = {7'b0, act_q[ldn_q]};
    else if (in_tbl && (ldn_q == TBL_LDN))      cfg_rdata = ent_byte(ent_q[ent_no], ofs[1:0]);
  end
endmodule

// File: rtl/pnp_bar_match.sv
module pnp_bar_match
  import pnp_cfg_pkg::*;
#(
  parameter int NENT = 8
) (
  input  bar_ent_t [NENT-1:0] ent,
  input  logic [NDEV-1:0]     act,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic                look_en,
  output logic                sel_hit,
  output logic [NDEV-1:0]     sel_onehot,
  output logic [7:0]          sel_offset
);
  localparam int ENT_W = (NENT > 1) ? $clog2(NENT) : 1;

  logic [NENT-1:0]  hit_v;
  logic [ENT_W-1:0] win;

  genvar g;
  generate
    for (g = 0; g < NENT; g++) begin : g_ent
      logic [ADDR_W-1:0] keep;
      assign keep     = ~{{(ADDR_W-8){1'b0}}, ent[g].mask};
      assign hit_v[g] = ent[g].vld && act[ent[g].ldn] && (ent[g].base != '0) &&
                        ((host_addr & keep) == (ent[g].base & keep));
    end
  endgenerate

  // lowest-numbered hit wins
  always_comb begin
    win = '0;
    for (int k = NENT - 1; k >= 0; k--) begin
      if (hit_v[k]) win = ENT_W'(k);
    end
  end

  assign sel_hit    = look_en && (|hit_v);
  assign sel_onehot = sel_hit ? (NDEV'(1) << ent[win].ldn) : '0;
  assign sel_offset = sel_hit ? (host_addr[7:0] & ent[win].mask) : 8'h00;
endmodule

// File: rtl/pnp_cfg_decoder.sv
module pnp_cfg_decoder
  import pnp_cfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CFG_BASE = 16'h002E,
  parameter int                NENT     = 8,
  parameter logic [LDN_W-1:0]  TBL_LDN  = 4'hC,
  parameter logic [7:0]        TBL_BASE = 8'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              sel_hit,
  output logic [15:0]       sel_onehot,
  output logic [7:0]        sel_offset
);
  logic [1:0]          rst_sync_q;
  logic                rst_sync_n;
  logic                cfg_open;
  logic [7:0]          idx_q, cfg_rdata;
  logic [NDEV-1:0]     act_q;
  bar_ent_t [NENT-1:0] ent_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  pnp_unlock_fsm #(.CFG_BASE(CFG_BASE)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .host_addr(host_addr),
    .host_wr(host_wr), .host_wdata(host_wdata), .cfg_open(cfg_open)
  );

  pnp_cfg_regs #(
    .CFG_BASE(CFG_BASE), .NENT(NENT), .TBL_LDN(TBL_LDN), .TBL_BASE(TBL_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .cfg_open(cfg_open), .host_addr(host_addr),
    .host_wr(host_wr), .host_wdata(host_wdata), .idx_q(idx_q),
    .cfg_rdata(cfg_rdata), .act_q(act_q), .ent_q(ent_q)
  );

  pnp_bar_match #(.NENT(NENT)) u_match (
    .ent(ent_q), .act(act_q), .host_addr(host_addr),
    .look_en(!cfg_open && (host_rd || host_wr)),
    .sel_hit(sel_hit), .sel_onehot(sel_onehot), .sel_offset(sel_offset)
  );

  always_comb begin
    host_rdata = 8'hFF;
    if (cfg_open && host_addr == CFG_BASE)               host_rdata = idx_q;
    else if (cfg_open && host_addr == CFG_BASE + 1'b1)   host_rdata = cfg_rdata;
  end
endmodule

// File: rtl/pnp_cfg_decoder_chk.sv
module pnp_cfg_decoder_chk #(
  parameter logic [15:0] CFG_BASE = 16'h002E
) (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        cfg_open,
  input logic [15:0] host_addr,
  input logic        host_wr,
  input logic        host_rd,
  input logic [7:0]  host_wdata,
  input logic [7:0]  host_rdata,
  input logic        sel_hit,
  input logic [15:0] sel_onehot,
  input logic [7:0]  sel_offset
);
  a_r1_open: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_wr && host_addr == CFG_BASE && !cfg_open && host_wdata == 8'h55) |=> cfg_open);

  a_r1_close: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (host_wr && host_addr == CFG_BASE && cfg_open && host_wdata == 8'hAA) |=> !cfg_open);

  a_r1_stay_locked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_open && !(host_wr && host_addr == CFG_BASE && host_wdata == 8'h55)) |=> !cfg_open);

  a_r2_locked_read: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_open && host_rd && (host_addr == CFG_BASE || host_addr == CFG_BASE + 16'd1))
      |-> host_rdata == 8'hFF);

  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_hit |-> $onehot(sel_onehot));

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_open || !(host_rd || host_wr)) |-> (!sel_hit && sel_onehot == 16'h0 && sel_offset == 8'h0));

  // R10: held in reset means locked
  always @(posedge clk) begin
    if (!rst_sync_n) a_r10_reset_locked: assert (!cfg_open);
  end
endmodule

bind pnp_cfg_decoder pnp_cfg_decoder_chk #(.CFG_BASE(CFG_BASE)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .cfg_open(cfg_open), .host_addr(host_addr),
  .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .sel_hit(sel_hit), .sel_onehot(sel_onehot),
  .sel_offset(sel_offset)
);

// File: tb/pnp_cfg_decoder_bench.sv
module pnp_cfg_decoder_bench;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] IDX = 16'h002E;
  localparam logic [15:0] DAT = 16'h002F;

  // {addr[31:16], 3'b0, hit[12], ldn[11:8], offset[7:0]}
  localparam int NVEC = 15;
  localparam logic [31:0] VEC [NVEC] = '{
    {16'h0A00, 4'h1, 4'hA, 8'h00},
    {16'h0A3F, 4'h1, 4'hA, 8'h3F},
    {16'h0A40, 4'h0, 4'h0, 8'h00},
    {16'h0A25, 4'h1, 4'hA, 8'h25},
    {16'h03F8, 4'h1, 4'h7, 8'h00},
    {16'h03FF, 4'h1, 4'h7, 8'h07},
    {16'h03F7, 4'h0, 4'h0, 8'h00},
    {16'h0C80, 4'h1, 4'hC, 8'h00},
    {16'h0C81, 4'h1, 4'hC, 8'h01},
    {16'h0C82, 4'h0, 4'h0, 8'h00},
    {16'h0003, 4'h0, 4'h0, 8'h00},
    {16'h0000, 4'h0, 4'h0, 8'h00},
    {16'h0302, 4'h0, 4'h0, 8'h00},
    {16'h0401, 4'h0, 4'h0, 8'h00},
    {16'h8A00, 4'h0, 4'h0, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] host_addr;
  logic        host_wr, host_rd;
  logic [7:0]  host_wdata, host_rdata;
  logic        sel_hit;
  logic [15:0] sel_onehot;
  logic [7:0]  sel_offset;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  pnp_cfg_decoder u_pnp_cfg_decoder (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sel_hit(sel_hit), .sel_onehot(sel_onehot), .sel_offset(sel_offset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_rd(logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 v = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic set_reg(logic [7:0] i, logic [7:0] v);
    bus_wr(IDX, i);
    bus_wr(DAT, v);
  endtask

  task automatic get_reg(logic [7:0] i, output logic [7:0] v);
    bus_wr(IDX, i);
    bus_rd(DAT, v);
  endtask

  task automatic probe(string req, logic [15:0] a, logic strobe,
                       logic hit, logic [3:0] ldn, logic [7:0] off);
    @(negedge clk);
    host_addr = a; host_rd = strobe;
    #1;
    check(req, {31'b0, sel_hit}, {31'b0, hit});
    check(req, {16'b0, sel_onehot}, hit ? (32'd1 << ldn) : 32'd0);
    check(req, {24'b0, sel_offset}, {24'b0, off});
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic activate(logic [7:0] dev);
    set_reg(8'h07, dev);
    set_reg(8'h30, 8'h01);
  endtask

  task automatic put_entry(int e, logic [7:0] m, logic [7:0] b1, logic [15:0] base);
    set_reg(8'(8'h60 + 4*e),     m);
    set_reg(8'(8'h61 + 4*e),     b1);
    set_reg(8'(8'h62 + 4*e),     base[7:0]);
    set_reg(8'(8'h63 + 4*e),     base[15:8]);
  endtask

  initial begin
    logic [7:0] v;
    host_addr = '0; host_wr = 0; host_rd = 0; host_wdata = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    bus_rd(DAT, v); check("R10 locked after reset", v, 8'hFF);
    bus_wr(IDX, 8'h12);                                    // R1 non-magic while locked
    bus_rd(IDX, v); check("R1 non-magic keeps locked", v, 8'hFF);
    bus_wr(IDX, 8'h55);
    get_reg(8'h07, v); check("R10 ldn cleared / R3", v, 8'h00);
    get_reg(8'h30, v); check("R10 activate cleared", v, 8'h00);
    set_reg(8'h07, 8'h0C);
    get_reg(8'h61, v); check("R10 entry cleared", v, 8'h00);

    // R6 table device inactive
    set_reg(8'h60, 8'h3F);
    get_reg(8'h60, v); check("R6 write ignored while inactive", v, 8'h00);

    activate(8'h0C);
    get_reg(8'h30, v); check("R4 activate readback", v, 8'h01);
    bus_rd(IDX, v); check("R3 index readback", v, 8'h30);
    put_entry(0, 8'h3F, 8'h8A, 16'h0A00);
    put_entry(1, 8'h07, 8'h87, 16'h03F8);
    put_entry(2, 8'h0F, 8'h80, 16'h0A20);
    put_entry(3, 8'h01, 8'h8C, 16'h0C80);
    put_entry(4, 8'h07, 8'h88, 16'h0000);
    put_entry(5, 8'h07, 8'h85, 16'h0300);
    put_entry(6, 8'h07, 8'h07, 16'h0400);
    set_reg(8'h7D, 8'hFA);
    get_reg(8'h7D, v); check("R5 byte1 bits 6:4 read zero", v, 8'h8A);
    get_reg(8'h60, v); check("R5 mask readback", v, 8'h3F);
    get_reg(8'h62, v); check("R5 base low readback", v, 8'h00);
    get_reg(8'h63, v); check("R5 base high readback", v, 8'h0A);
    get_reg(8'h65, v); check("R5 byte1 readback", v, 8'h87);

    activate(8'h0A); activate(8'h07); activate(8'h00); activate(8'h08);
    set_reg(8'h60, 8'h01);                                 // R6 wrong device selected
    set_reg(8'h07, 8'h0C);
    get_reg(8'h60, v); check("R6 write ignored wrong ldn", v, 8'h3F);
    get_reg(8'h07, v); check("R3 ldn select readback", v, 8'h0C);
    bus_rd(IDX, v); check("R3 index port", v, 8'h07);
    get_reg(8'h63, v);

    probe("R9 no decode while open", 16'h0C80, 1'b1, 1'b0, 4'h0, 8'h00);

    // R2 locked writes ignored
    bus_wr(IDX, 8'hAA);
    bus_rd(IDX, v); check("R1 close / R2 index reads FF", v, 8'hFF);
    bus_wr(IDX, 8'h30);
    bus_wr(DAT, 8'h00);
    bus_wr(IDX, 8'h55);
    bus_rd(IDX, v); check("R2 locked index write ignored", v, 8'h63);
    bus_rd(DAT, v); check("R2 locked data write ignored", v, 8'h0A);
    bus_wr(IDX, 8'hAA);

    // vector table (R7, R8, R11)
    for (int n = 0; n < NVEC; n++) begin
      probe($sformatf("R7/R8/R11 vec%0d", n), VEC[n][31:16], 1'b1,
            VEC[n][12], VEC[n][11:8], VEC[n][7:0]);
    end
    probe("R9 no strobe", 16'h0C80, 1'b0, 1'b0, 4'h0, 8'h00);

    // R8 after invalidating entry 0, entry 2 takes over
    bus_wr(IDX, 8'h55);
    set_reg(8'h61, 8'h0A);
    set_reg(8'h07, 8'h07);
    set_reg(8'h30, 8'h00);
    get_reg(8'h30, v); check("R4 deactivate readback", v, 8'h00);
    bus_wr(IDX, 8'hAA);
    probe("R8 next entry wins", 16'h0A25, 1'b1, 1'b1, 4'h0, 8'h05);
    probe("R7 inactive target misses", 16'h03F8, 1'b1, 1'b0, 4'h0, 8'h00);

    // R10 reset mid-run
    do_reset();
    probe("R10 decode cleared", 16'h0C80, 1'b1, 1'b0, 4'h0, 8'h00);
    bus_rd(DAT, v); check("R10 locked again", v, 8'hFF);
    bus_wr(IDX, 8'h55);
    set_reg(8'h07, 8'h0C);
    get_reg(8'h63, v); check("R10 entry base cleared", v, 8'h00);

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule